// File: doc/BRIEF.md
# Interleaved I/Q Sample Splitter

This block takes a single stream of signed or unsigned sample words, running at twice the rate of each output channel, and sorts it into an in-phase (I) and a quadrature (Q) channel. Accepted samples are handed out in turn, first to an I holding register and then to the Q side. Once the Q member of a pair arrives, the two leave together as one output beat. The upstream source offers samples with `in_valid`/`in_ready`, and the downstream consumer takes pairs with `out_valid`/`out_ready`.

The `sel_iq` control sets which sample starts a pair. On any rising edge of `sel_iq`, the next accepted sample is treated as an I sample. From then on the I/Q alternation runs on its own. `sel_iq` may toggle at the channel rate, arrive as one isolated pulse, or be a single step to high. It is assumed to be asynchronous, so it passes through a synchronizer. The data path is delayed by the same number of cycles, so the realignment still lands on the sample accepted in the cycle where `sel_iq` was first seen high.

Back-pressure rules:
- A sample moves only in a cycle where `in_valid` and `in_ready` are both high.
- A pair moves only in a cycle where `out_valid` and `out_ready` are both high.
- `in_ready` is derived only from internal state and never from `out_ready` in the same cycle.
- `in_ready` drops once the samples already committed inside the block could fill the whole pair store.
- While `out_valid` is high, the presented pair is held until it is taken.

Top module: `iq_deinterleave`

## Requirements
- R1: After reset `out_valid` is 0, `out_i` and `out_q` read 0, `in_ready` is 1, and the steering pointer selects I.
- R2: With no `sel_iq` rising edge, accepted samples s0, s1, s2, s3, ... leave as pairs (I=s0, Q=s1), (I=s2, Q=s3), and so on, in order.
- R3: If `sel_iq` is sampled low on one rising clock edge and high on the next, the first sample accepted on that second edge or later becomes the I member of a new pair.
- R4: An I sample that is still waiting for its Q partner when a realignment takes effect is discarded and never appears on `out_i`.
- R5: A `sel_iq` that toggles so that each rising edge coincides with an I sample leaves the pairing unchanged, with no skipped or repeated sample.
- R6: A single isolated pulse and a single step to a held high level each realign exactly once; a level that stays high causes no further realignment.
- R7: A pair is emitted only after its Q sample is accepted. With the pair store empty, `out_valid` rises SYNC_STAGES+1 clock edges after the edge that accepts the Q sample. A lone I sample never produces `out_valid`.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_i` and `out_q` stay unchanged on the next edge.
- R9: `in_valid` has no effect while `in_ready` is 0. With `out_ready` held 0 from an empty, aligned state, exactly 2*PAIR_DEPTH+1 samples are accepted before `in_ready` falls. No completed pair is ever lost or duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_iq | input | 1 | Pair alignment control; a rising edge forces the next sample to I |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Block can take an input sample |
| in_data | input | DATA_W | Interleaved input sample |
| out_valid | output | 1 | An I/Q pair is presented |
| out_ready | input | 1 | Consumer takes the presented pair |
| out_i | output | DATA_W | In-phase sample of the presented pair |
| out_q | output | DATA_W | Quadrature sample of the presented pair |

## Verification
The bench feeds numbered ramps and checks four `sel_iq` patterns. With no edges, the I outputs must land on even ramp positions and the Q outputs on odd ones. A single pulse and a step placed on a Q position must each drop exactly the waiting I and restart there. A toggle that agrees with the current phase must change nothing, which separates an edge detector from a level-sensitive one. Random valid, ready and `sel_iq` traffic with a fixed seed is then compared against a bench model. That run, together with a directed stall that fills the pair store, separates correct credit accounting from lost or duplicated pairs.

// File: rtl/iq_deint_pkg.sv
package iq_deint_pkg;
  // Which channel the next accepted sample is steered to.
  typedef enum logic {
    LANE_I = 1'b0,
    LANE_Q = 1'b1
  } lane_e;
endpackage

// File: rtl/iq_edge_sync.sv
// Multi-flop synchronizer for the alignment control, followed by a
// registered rising-edge detector. The latency from the control to rise_o
// is SYNC_STAGES+1 clock edges.
module iq_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_raw,
  output logic rise_o
);
  logic [SYNC_STAGES-1:0] chain_q;
  logic                   level_d_q;
  logic                   rise_q;

  for (genvar k = 0; k < SYNC_STAGES; k++) begin : g_sync
    if (k == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) chain_q[k] <= 1'b0;
        else        chain_q[k] <= sel_raw;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rst_n) chain_q[k] <= 1'b0;
        else        chain_q[k] <= chain_q[k-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      level_d_q <= 1'b0;
      rise_q    <= 1'b0;
    end else begin
      level_d_q <= chain_q[SYNC_STAGES-1];
      rise_q    <= chain_q[SYNC_STAGES-1] & ~level_d_q;
    end
  end

  assign rise_o = rise_q;
endmodule

// File: rtl/iq_align_delay.sv
// Fixed-latency sample pipe. It matches the synchronizer latency so that
// each sample meets the edge flag of the cycle in which it was accepted.
module iq_align_delay #(
  parameter int W      = 14,
  parameter int STAGES = 3,
  parameter int OCC_W  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_vld,
  input  logic [W-1:0]     in_dat,
  output logic             out_vld,
  output logic [W-1:0]     out_dat,
  output logic [OCC_W-1:0] occupancy
);
  logic [STAGES:0] vld_c;
  logic [W-1:0]    dat_c [STAGES+1];

  assign vld_c[0] = in_vld;
  assign dat_c[0] = in_dat;

  for (genvar k = 1; k <= STAGES; k++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld_c[k] <= 1'b0;
        dat_c[k] <= '0;
      end else begin
        vld_c[k] <= vld_c[k-1];
        dat_c[k] <= dat_c[k-1];
      end
    end
  end

  always_comb begin
    occupancy = '0;
    for (int k = 1; k <= STAGES; k++) begin
      occupancy = occupancy + OCC_W'(vld_c[k]);
    end
  end

  assign out_vld = vld_c[STAGES];
  assign out_dat = dat_c[STAGES];
endmodule

// File: rtl/iq_steer.sv
// Steering pointer plus I holding register. A realignment request, either
// fresh or pending from an empty cycle, forces the next sample to I.
module iq_steer
  import iq_deint_pkg::*;
#(
  parameter int W = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         realign_pulse,
  input  logic         smp_vld,
  input  logic [W-1:0] smp_dat,
  output logic         pair_push,
  output logic [W-1:0] pair_i,
  output logic [W-1:0] pair_q,
  output logic         i_held
);
  lane_e        ptr_q;
  logic         pend_q;
  logic         held_q;
  logic [W-1:0] i_lat_q;
  logic         realign;
  logic         to_i;

  assign realign = realign_pulse | pend_q;
  assign to_i    = realign | (ptr_q == LANE_I);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q   <= LANE_I;
      pend_q  <= 1'b0;
      held_q  <= 1'b0;
      i_lat_q <= '0;
    end else if (smp_vld) begin
      pend_q <= 1'b0;
      if (to_i) begin
        i_lat_q <= smp_dat;   // replaces any unpaired I (R4)
        held_q  <= 1'b1;
        ptr_q   <= LANE_Q;
      end else begin
        held_q  <= 1'b0;
        ptr_q   <= LANE_I;
      end
    end else if (realign_pulse) begin
      pend_q <= 1'b1;         // edge without a sample: wait for the next one (R3)
    end
  end

  assign pair_push = smp_vld & ~to_i;
  assign pair_i    = i_lat_q;
  assign pair_q    = smp_dat;
  assign i_held    = held_q;
endmodule

// File: rtl/iq_pair_fifo.sv
// Small pair store that carries the I and Q words side by side.
module iq_pair_fifo #(
  parameter int W     = 14,
  parameter int DEPTH = 4,
  parameter int LW    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  push_i,
  input  logic [W-1:0]  push_q,
  input  logic          pop,
  output logic [W-1:0]  head_i,
  output logic [W-1:0]  head_q,
  output logic          not_empty,
  output logic [LW-1:0] level
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem_i [DEPTH];
  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic [LW-1:0] lvl_q;
  logic          do_pop;

  assign do_pop = pop & (lvl_q != '0);

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH-1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      lvl_q <= '0;
      for (int k = 0; k < DEPTH; k++) begin
        mem_i[k] <= '0;
        mem_q[k] <= '0;
      end
    end else begin
      if (push) begin
        mem_i[wr_q] <= push_i;
        mem_q[wr_q] <= push_q;
        wr_q        <= bump(wr_q);
      end
      if (do_pop) rd_q <= bump(rd_q);
      case ({push, do_pop})
        2'b10:   lvl_q <= lvl_q + LW'(1);
        2'b01:   lvl_q <= lvl_q - LW'(1);
        default: lvl_q <= lvl_q;
      endcase
    end
  end

  assign head_i    = mem_i[rd_q];
  assign head_q    = mem_q[rd_q];
  assign not_empty = (lvl_q != '0);
  assign level     = lvl_q;
endmodule

// File: rtl/iq_deinterleave.sv
// Top level: synchronizer and edge detect, matching sample delay,
// steering, pair store and input credit.
module iq_deinterleave #(
  parameter int DATA_W      = 14,
  parameter int SYNC_STAGES = 2,
  parameter int PAIR_DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_iq,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_i,
  output logic [DATA_W-1:0] out_q
);
  localparam int DLY   = SYNC_STAGES + 1;
  localparam int OCC_W = $clog2(DLY + 1);
  localparam int LW    = $clog2(PAIR_DEPTH + 1);
  localparam int CAP   = 2 * PAIR_DEPTH + 1;
  localparam int CW    = $clog2(CAP + DLY + 2) + 1;

  logic              rise;
  logic              d_vld;
  logic [DATA_W-1:0] d_dat;
  logic [OCC_W-1:0]  occ;
  logic              push;
  logic [DATA_W-1:0] p_i, p_q;
  logic              held;
  logic [LW-1:0]     lvl;
  logic              fire_in;
  logic [CW-1:0]     committed;

  assign fire_in = in_valid & in_ready;

  iq_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sel_raw(sel_iq), .rise_o(rise)
  );

  iq_align_delay #(.W(DATA_W), .STAGES(DLY), .OCC_W(OCC_W)) u_dly (
    .clk(clk), .rst_n(rst_n), .in_vld(fire_in), .in_dat(in_data),
    .out_vld(d_vld), .out_dat(d_dat), .occupancy(occ)
  );

  iq_steer #(.W(DATA_W)) u_steer (
    .clk(clk), .rst_n(rst_n), .realign_pulse(rise),
    .smp_vld(d_vld), .smp_dat(d_dat),
    .pair_push(push), .pair_i(p_i), .pair_q(p_q), .i_held(held)
  );

  iq_pair_fifo #(.W(DATA_W), .DEPTH(PAIR_DEPTH), .LW(LW)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .push_i(p_i), .push_q(p_q),
    .pop(out_ready), .head_i(out_i), .head_q(out_q),
    .not_empty(out_valid), .level(lvl)
  );

  // Every sample in flight, the waiting I and two words per stored pair
  // count against the store; stop accepting once that reaches CAP (R9).
  assign committed = CW'(occ) + CW'(held) + (CW'(lvl) << 1);
  assign in_ready  = (committed < CW'(CAP));
endmodule

// File: rtl/iq_deinterleave_chk.sv
module iq_deinterleave_chk #(
  parameter int DATA_W = 14
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_i,
  input logic [DATA_W-1:0] out_q
);
  logic [31:0] acc_cnt, pop_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_cnt <= '0;
      pop_cnt <= '0;
    end else begin
      if (in_valid && in_ready)   acc_cnt <= acc_cnt + 32'd1;
      if (out_valid && out_ready) pop_cnt <= pop_cnt + 32'd1;
    end
  end

  // R1: the first cycle out of reset shows an idle, zeroed output
  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!out_valid && out_i == '0 && out_q == '0 && in_ready));

  // R8: a stalled pair is held
  a_r8_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_i) && $stable(out_q)));

  // R7: each pair leaving needs two accepted samples behind it
  a_r7_pair_needs_two: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |-> (acc_cnt >= (pop_cnt << 1) + 32'd2));

  // R9: with everything delivered, the input must be open
  a_r9_ready_when_drained: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_cnt == (pop_cnt << 1)) |-> in_ready);
endmodule

bind iq_deinterleave iq_deinterleave_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_i(out_i), .out_q(out_q)
);

// File: tb/tb_iq_deinterleave.sv
module tb_iq_deinterleave;
  localparam int W     = 14;
  localparam int SYNC  = 2;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic         rst_n = 1'b0;
  logic         sel_iq = 1'b0;
  logic         in_valid = 1'b0;
  logic         out_ready = 1'b0;
  logic [W-1:0] in_data = '0;
  logic         in_ready, out_valid;
  logic [W-1:0] out_i, out_q;

  iq_deinterleave #(.DATA_W(W), .SYNC_STAGES(SYNC), .PAIR_DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .sel_iq(sel_iq), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_i(out_i), .out_q(out_q)
  );

  int total = 0, bad = 0, cyc = 0;
  bit m_prev_sel = 0, m_pend = 0, m_ptr_q = 0;
  logic [W-1:0] m_ilat = '0;
  logic [W-1:0] exp_i[$], exp_q[$], got_i[$], got_q[$];
  bit hold_armed = 0;
  logic [W-1:0] hold_i, hold_q;
  bit last_fire = 0, last_q = 0;
  int q_cyc = 0;

  function automatic logic [W-1:0] ramp(input int n);
    return W'(n);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic eval();
    bit fin, fout;
    logic [W-1:0] ei, eq;
    fin  = in_valid && in_ready;
    fout = out_valid && out_ready;
    if (hold_armed) begin
      chk(out_valid === 1'b1, "R8", "valid dropped while stalled", int'(out_valid), 1);
      chk(out_i === hold_i && out_q === hold_q, "R8", "pair changed while stalled",
          int'(out_i), int'(hold_i));
    end
    hold_armed = out_valid && !out_ready;
    hold_i = out_i; hold_q = out_q;
    if (fout) begin
      if (exp_i.size() == 0) begin
        chk(0, "R9", "unexpected pair", int'(out_i), -1);
      end else begin
        ei = exp_i.pop_front(); eq = exp_q.pop_front();
        chk(out_i === ei, "R2", "I word", int'(out_i), int'(ei));
        chk(out_q === eq, "R2", "Q word", int'(out_q), int'(eq));
      end
      got_i.push_back(out_i); got_q.push_back(out_q);
    end
    // reference model
    if (sel_iq && !m_prev_sel) m_pend = 1;
    m_prev_sel = sel_iq;
    last_q = 0;
    if (fin) begin
      if (m_pend || !m_ptr_q) begin
        m_ilat = in_data; m_ptr_q = 1; m_pend = 0;
      end else begin
        exp_i.push_back(m_ilat); exp_q.push_back(in_data);
        m_ptr_q = 0; last_q = 1; q_cyc = cyc;
      end
    end
    last_fire = fin;
    cyc++;
  endtask

  task automatic step(input bit s, input bit v, input logic [W-1:0] d, input bit r);
    @(negedge clk);
    sel_iq = s; in_valid = v; in_data = d; out_ready = r;
    #1;
    eval();
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step(1'b0, 1'b0, '0, 1'b1);
  endtask

  task automatic stream(input int base, input int cnt, input int mode);
    int n = 0;
    bit pulsed = 0;
    bit s;
    while (n < cnt) begin
      case (mode)
        1:       s = (n == 5) && !pulsed;   // single pulse on a Q slot
        2:       s = (n >= 4);              // step on a Q slot, held high
        3:       s = (n % 2 == 0);          // toggle agreeing with phase
        default: s = 0;
      endcase
      step(s, 1'b1, ramp(base + n), 1'b1);
      if (s) pulsed = 1;
      if (last_fire) n++;
    end
  endtask

  initial begin
    int seen, accepted, found;
    bit rs;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1
    chk(out_valid === 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
    chk(out_i === '0 && out_q === '0, "R1", "outputs after reset", int'(out_i), 0);
    chk(in_ready === 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);

    // R7: latency and no output for a lone I
    step(0, 1, ramp(100), 1);
    step(0, 1, ramp(101), 1);
    chk(last_q, "R7", "second sample taken as Q", int'(last_q), 1);
    seen = -1;
    for (int k = 1; k <= 8; k++) begin
      step(0, 0, '0, 1);
      if (out_valid && seen < 0) seen = k;
    end
    chk(seen == SYNC + 2, "R7", "pair latency in evals", seen, SYNC + 2);
    step(0, 1, ramp(102), 1);
    found = 0;
    for (int k = 0; k < 10; k++) begin
      step(0, 0, '0, 1);
      if (out_valid) found++;
    end
    chk(found == 0, "R7", "valid for a lone I", found, 0);
    step(0, 1, ramp(103), 1);
    idle(10);

    // R2: plain ramp
    got_i.delete(); got_q.delete();
    stream(200, 20, 0);
    idle(12);
    chk(got_i.size() == 10, "R2", "pair count", got_i.size(), 10);
    for (int k = 0; k < got_i.size() && k < 10; k++) begin
      chk(got_i[k] == ramp(200 + 2*k), "R2", "I on even slot", int'(got_i[k]), 200 + 2*k);
      chk(got_q[k] == ramp(201 + 2*k), "R2", "Q on odd slot", int'(got_q[k]), 201 + 2*k);
    end

    // R3/R4: single pulse on a Q slot
    got_i.delete(); got_q.delete();
    stream(300, 12, 1);
    idle(12);
    chk(got_i.size() == 5, "R3", "pairs after pulse", got_i.size(), 5);
    if (got_i.size() > 2) begin
      chk(got_i[2] == ramp(305), "R3", "I restarts at pulse", int'(got_i[2]), 305);
      chk(got_q[2] == ramp(306), "R3", "Q follows restart", int'(got_q[2]), 306);
    end
    found = 0;
    foreach (got_i[k]) if (got_i[k] == ramp(304) || got_q[k] == ramp(304)) found++;
    chk(found == 0, "R4", "dropped I appeared", found, 0);

    // R6: step to a held level on a Q slot (311 is still waiting as I)
    got_i.delete(); got_q.delete();
    stream(400, 10, 2);
    step(1, 0, '0, 1);
    idle(12);
    chk(got_i.size() == 5, "R6", "pairs after step", got_i.size(), 5);
    if (got_i.size() > 3) begin
      chk(got_i[2] == ramp(404), "R6", "I restarts at step", int'(got_i[2]), 404);
      chk(got_i[3] == ramp(406), "R6", "no second realign", int'(got_i[3]), 406);
    end

    // R5: periodic toggle agreeing with phase
    got_i.delete(); got_q.delete();
    stream(500, 32, 3);
    idle(12);
    chk(got_i.size() == 16, "R5", "pairs with agreeing toggle", got_i.size(), 16);
    for (int k = 0; k < got_i.size() && k < 16; k++) begin
      chk(got_i[k] == ramp(500 + 2*k) && got_q[k] == ramp(501 + 2*k), "R5",
          "pair unchanged by toggle", int'(got_i[k]), 500 + 2*k);
    end

    // R9: credit limit under full stall, in_valid held high throughout
    accepted = 0;
    for (int k = 0; k < 30; k++) begin
      step(0, 1, ramp(600 + k), 0);
      if (last_fire) accepted++;
    end
    chk(accepted == 2*DEPTH + 1, "R9", "samples taken while stalled", accepted, 2*DEPTH + 1);
    chk(in_ready === 1'b0, "R9", "in_ready while full", int'(in_ready), 0);
    idle(20);

    // random traffic against the model (R2, R3, R8, R9)
    rs = 0;
    for (int k = 0; k < 4000; k++) begin
      if ($urandom % 16 == 0) rs = !rs;
      step(rs, ($urandom % 4) != 0, W'($urandom), ($urandom % 3) != 0);
    end
    idle(30);
    chk(exp_i.size() == 0, "R9", "pairs left undelivered", exp_i.size(), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule